// File: doc/BRIEF.md
# Multidrop Line Direction and Address Filter

This block sits beside one UART channel and adds what a half-duplex, multidrop serial bus needs. Its first half decides the level of the RTS line that enables the external line driver. When the automatic direction mode is off, RTS comes from a software-controlled bit, or from the hardware flow-control logic if that is switched on. When the automatic mode is on, it overrides both of those sources. RTS then goes active as soon as the transmitter starts a character. After the last stop bit has left, RTS stays active for a programmable number of bit-time strobes, which gives the remote transceivers time to turn around, and then it is released.

The second half decides which received characters reach the receive FIFO. Each received character carries a ninth-bit flag that marks it as an address. With filtering enabled, data characters are dropped until an address character equal to the node address arrives. That address character is itself passed on, so software can see that the node was addressed. The data characters that follow are accepted until an address that does not match turns acceptance off again.

Top module: `mdrop_link_ctrl`

## Requirements
- R1: With automatic direction off and flow control off, `rts_o` follows `man_rts` in the same cycle.
- R2: With automatic direction off and flow control on, `rts_o` follows `fc_rts` in the same cycle, and `man_rts` has no effect.
- R3: With automatic direction on, `man_rts` and `fc_rts` have no effect. RTS is inactive while the transmitter is idle and becomes active on the clock edge that first samples `tx_busy` high. With the default polarity, `rts_o` = 1 means the driver is enabled.
- R4: RTS stays active while `tx_busy` is high or `tx_empty` is low.
- R5: Once `tx_busy` is low and `tx_empty` is high, RTS stays active until `turn_cnt` bit strobes (`bit_tick` pulses) have been sampled. It drops on the edge that samples the last of them. Strobes that occur during transmission are not counted.
- R6: With `turn_cnt` = 0, RTS drops on the edge that first samples the transmitter done.
- R7: New transmit activity during the turnaround window keeps RTS active and restarts the turnaround count from zero.
- R8: With filtering off, every valid received character is accepted, whether it is an address or data.
- R9: With filtering on and no match held, data characters and non-matching address characters (`rx_is_addr` = 1) are not accepted.
- R10: A valid address character equal to `node_addr` is accepted, and data characters after it are accepted.
- R11: A non-matching address character arriving while a match is held is not accepted, and it ends acceptance of the data that follows.
- R12: Turning filtering off clears the held match, so after filtering is enabled again, data is dropped until a new match arrives. `rx_accept` is never high without `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_dir_en | input | 1 | Automatic direction mode enable |
| man_rts | input | 1 | Software RTS bit (1 = active) |
| fc_en | input | 1 | Hardware flow control enable |
| fc_rts | input | 1 | RTS requested by flow control (1 = active) |
| tx_busy | input | 1 | Transmit shift register is sending a character |
| tx_empty | input | 1 | Transmit FIFO holds no character |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| turn_cnt | input | 8 | Turnaround delay in bit times |
| filt_en | input | 1 | Address filtering enable |
| node_addr | input | 8 | Address of this node |
| rx_valid | input | 1 | Received character present this cycle |
| rx_byte | input | 8 | Received character |
| rx_is_addr | input | 1 | Ninth-bit flag: the character is an address |
| rts_o | output | 1 | Line driver enable (polarity set by parameter) |
| rx_accept | output | 1 | Write the current character into the receive FIFO |

## Verification
The bench checks the exact edge on which RTS is released. A turnaround counter that is off by one, or that counts strobes arriving mid-character, would release the line a bit time early or late. A zero turnaround is checked separately, because a counter that wraps would hold RTS for 256 bit times. A retransmission during the turnaround window is checked for a restarted count, since a design that kept the old count would drop the driver while the next frame is on the line. On the receive side, the bench checks that the matching address itself is accepted, that a foreign address withdraws acceptance, and that a held match does not survive turning the filter off and on again. A design that kept a stale match would leak another node's data into the FIFO.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_t;
endpackage

// File: rtl/mdrop_dir_ctrl.sv
module mdrop_dir_ctrl
  import mdrop_pkg::*;
#(
  parameter int TURN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_dir_en,
  input  logic              tx_busy,
  input  logic              tx_empty,
  input  logic              bit_tick,
  input  logic [TURN_W-1:0] turn_cnt,
  output logic              auto_rts
);
  localparam int CNT_W = TURN_W + 1;

  dir_state_t       state_q, state_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_inc;
  logic             tx_active, tx_done, turn_zero;

  assign tx_active = tx_busy || !tx_empty;
  assign tx_done   = !tx_busy && tx_empty;
  assign turn_zero = (turn_cnt == '0);
  assign cnt_inc   = cnt_q + CNT_W'(1);

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    if (!auto_dir_en) begin
      state_nxt = DIR_IDLE;
      cnt_nxt   = '0;
    end else begin
      unique case (state_q)
        DIR_IDLE: begin
          if (tx_busy) state_nxt = DIR_SEND;
        end
        DIR_SEND: begin
          if (tx_done) begin
            cnt_nxt   = '0;
            state_nxt = turn_zero ? DIR_IDLE : DIR_HOLD;
          end
        end
        DIR_HOLD: begin
          if (tx_active) begin
            state_nxt = DIR_SEND;
            cnt_nxt   = '0;
          end else if (turn_zero) begin
            state_nxt = DIR_IDLE;
          end else if (bit_tick) begin
            if (cnt_inc >= {1'b0, turn_cnt}) begin
              state_nxt = DIR_IDLE;
              cnt_nxt   = '0;
            end else begin
              cnt_nxt = cnt_inc;
            end
          end
        end
        default: state_nxt = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end

  assign auto_rts = (state_q != DIR_IDLE);
endmodule

// File: rtl/mdrop_addr_filt.sv
module mdrop_addr_filt #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              filt_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_is_addr,
  output logic              rx_accept
);
  logic match_q, match_nxt, hit, acc;

  assign hit = (rx_byte == node_addr);

  always_comb begin
    match_nxt = match_q;
    acc       = 1'b0;
    if (!filt_en) begin
      match_nxt = 1'b0;
      acc       = rx_valid;
    end else if (rx_valid) begin
      if (rx_is_addr) begin
        match_nxt = hit;
        acc       = hit;
      end else begin
        acc = match_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_nxt;
  end

  assign rx_accept = acc;
endmodule

// File: rtl/mdrop_link_ctrl.sv
module mdrop_link_ctrl #(
  parameter int TURN_W      = 8,
  parameter int DATA_W      = 8,
  parameter bit RTS_ACT_LOW = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_dir_en,
  input  logic              man_rts,
  input  logic              fc_en,
  input  logic              fc_rts,
  input  logic              tx_busy,
  input  logic              tx_empty,
  input  logic              bit_tick,
  input  logic [TURN_W-1:0] turn_cnt,
  input  logic              filt_en,
  input  logic [DATA_W-1:0] node_addr,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_is_addr,
  output logic              rts_o,
  output logic              rx_accept
);
  logic auto_rts, rts_act;

  mdrop_dir_ctrl #(.TURN_W(TURN_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .auto_dir_en(auto_dir_en),
    .tx_busy(tx_busy), .tx_empty(tx_empty), .bit_tick(bit_tick),
    .turn_cnt(turn_cnt), .auto_rts(auto_rts)
  );

  mdrop_addr_filt #(.DATA_W(DATA_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .node_addr(node_addr),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_is_addr(rx_is_addr),
    .rx_accept(rx_accept)
  );

  // Source priority: automatic direction, then flow control, then software bit.
  always_comb begin
    if (auto_dir_en) rts_act = auto_rts;
    else if (fc_en)  rts_act = fc_rts;
    else             rts_act = man_rts;
  end

  generate
    if (RTS_ACT_LOW) begin : g_pol_low
      assign rts_o = ~rts_act;
    end else begin : g_pol_high
      assign rts_o = rts_act;
    end
  endgenerate
endmodule

// File: rtl/mdrop_link_chk.sv
module mdrop_link_chk #(
  parameter int TURN_W      = 8,
  parameter int DATA_W      = 8,
  parameter bit RTS_ACT_LOW = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_dir_en,
  input logic              tx_busy,
  input logic              tx_empty,
  input logic              bit_tick,
  input logic [TURN_W-1:0] turn_cnt,
  input logic              filt_en,
  input logic [DATA_W-1:0] node_addr,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_is_addr,
  input logic              rts_o,
  input logic              rx_accept
);
  logic on;
  assign on = rts_o ^ RTS_ACT_LOW;

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir_en && tx_busy |=> !auto_dir_en || on);

  assert_hold_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir_en && on && (tx_busy || !tx_empty) |=> !auto_dir_en || on);

  assert_no_early_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir_en && on && !bit_tick && (turn_cnt != '0) |=> !auto_dir_en || on);

  assert_zero_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dir_en && on && !tx_busy && tx_empty && (turn_cnt == '0)
    |=> !auto_dir_en || !on);

  assert_pass_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en && rx_valid |-> rx_accept);

  assert_foreign_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    filt_en && rx_valid && rx_is_addr && (rx_byte != node_addr) |-> !rx_accept);

  assert_own_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    filt_en && rx_valid && rx_is_addr && (rx_byte == node_addr) |-> rx_accept);

  assert_data_after_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    filt_en && $past(filt_en && rx_valid && rx_is_addr && (rx_byte == node_addr))
    && rx_valid && !rx_is_addr |-> rx_accept);

  assert_accept_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> rx_valid);
endmodule

bind mdrop_link_ctrl mdrop_link_chk #(
  .TURN_W(TURN_W), .DATA_W(DATA_W), .RTS_ACT_LOW(RTS_ACT_LOW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .auto_dir_en(auto_dir_en), .tx_busy(tx_busy),
  .tx_empty(tx_empty), .bit_tick(bit_tick), .turn_cnt(turn_cnt),
  .filt_en(filt_en), .node_addr(node_addr), .rx_valid(rx_valid),
  .rx_byte(rx_byte), .rx_is_addr(rx_is_addr), .rts_o(rts_o),
  .rx_accept(rx_accept)
);

// File: tb/test_mdrop_link_ctrl.sv
module test_mdrop_link_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       auto_dir_en, man_rts, fc_en, fc_rts;
  logic       tx_busy, tx_empty, bit_tick;
  logic [7:0] turn_cnt;
  logic       filt_en, rx_valid, rx_is_addr;
  logic [7:0] node_addr, rx_byte;
  logic       rts_o, rx_accept;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mdrop_link_ctrl i_mdrop_link_ctrl (
    .clk(clk), .rst_n(rst_n), .auto_dir_en(auto_dir_en), .man_rts(man_rts),
    .fc_en(fc_en), .fc_rts(fc_rts), .tx_busy(tx_busy), .tx_empty(tx_empty),
    .bit_tick(bit_tick), .turn_cnt(turn_cnt), .filt_en(filt_en),
    .node_addr(node_addr), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_is_addr(rx_is_addr), .rts_o(rts_o), .rx_accept(rx_accept)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_once();
    bit_tick = 1'b1;
    step();
    bit_tick = 1'b0;
  endtask

  task automatic t_reset();
    check(rts_o, 1'b0, "R1 reset rts");
    check(rx_accept, 1'b0, "R8 reset accept");
  endtask

  task automatic t_manual();
    man_rts = 1'b1; #1;
    check(rts_o, 1'b1, "R1 manual high");
    man_rts = 1'b0; #1;
    check(rts_o, 1'b0, "R1 manual low");
    fc_en = 1'b1; fc_rts = 1'b0; man_rts = 1'b1; #1;
    check(rts_o, 1'b0, "R2 flow low overrides manual");
    fc_rts = 1'b1; man_rts = 1'b0; #1;
    check(rts_o, 1'b1, "R2 flow high");
    step();
  endtask

  task automatic t_auto_start();
    man_rts = 1'b1; fc_en = 1'b1; fc_rts = 1'b1;
    auto_dir_en = 1'b1; turn_cnt = 8'd3; #1;
    check(rts_o, 1'b0, "R3 auto idle overrides others");
    step();
    check(rts_o, 1'b0, "R3 auto idle after edge");
    tx_busy = 1'b1; tx_empty = 1'b0; #1;
    check(rts_o, 1'b0, "R3 not before edge");
    step();
    check(rts_o, 1'b1, "R3 active after busy edge");
  endtask

  task automatic t_turnaround();
    // in SEND from t_auto_start; strobes here must not count
    tick_once(); tick_once(); tick_once(); tick_once();
    check(rts_o, 1'b1, "R4 busy holds");
    tx_busy = 1'b0; step();
    check(rts_o, 1'b1, "R4 fifo not empty holds");
    tx_empty = 1'b1; step();
    check(rts_o, 1'b1, "R5 enter turnaround");
    step(); step();
    check(rts_o, 1'b1, "R5 no strobe no release");
    tick_once();
    check(rts_o, 1'b1, "R5 after 1 of 3");
    tick_once();
    check(rts_o, 1'b1, "R5 after 2 of 3");
    tick_once();
    check(rts_o, 1'b0, "R5 released after 3");
  endtask

  task automatic t_zero_turn();
    turn_cnt = 8'd0;
    tx_busy = 1'b1; step();
    check(rts_o, 1'b1, "R6 started");
    tx_busy = 1'b0; step();
    check(rts_o, 1'b0, "R6 immediate release");
  endtask

  task automatic t_retrigger();
    turn_cnt = 8'd2;
    tx_busy = 1'b1; step();
    tx_busy = 1'b0; step();
    tick_once();
    check(rts_o, 1'b1, "R7 mid turnaround");
    tx_busy = 1'b1; step();
    check(rts_o, 1'b1, "R7 retrigger holds");
    tx_busy = 1'b0; step();
    tick_once();
    check(rts_o, 1'b1, "R7 count restarted");
    tick_once();
    check(rts_o, 1'b0, "R7 release after full count");
    auto_dir_en = 1'b0; #1;
    check(rts_o, 1'b1, "R2 flow resumes after auto off");
  endtask

  task automatic rx_char(input logic [7:0] b, input logic adr,
                         input logic exp, input string req);
    rx_byte = b; rx_is_addr = adr; rx_valid = 1'b1; #1;
    check(rx_accept, exp, req);
    step();
    rx_valid = 1'b0; rx_is_addr = 1'b0; #1;
    check(rx_accept, 1'b0, "R12 idle no accept");
  endtask

  task automatic t_filter();
    node_addr = 8'h5A;
    filt_en = 1'b0;
    rx_char(8'h11, 1'b0, 1'b1, "R8 data passes");
    rx_char(8'h33, 1'b1, 1'b1, "R8 address passes");
    filt_en = 1'b1;
    rx_char(8'h11, 1'b0, 1'b0, "R9 data dropped");
    rx_char(8'h33, 1'b1, 1'b0, "R9 foreign address dropped");
    rx_char(8'h5A, 1'b0, 1'b0, "R9 data equal to address dropped");
    rx_char(8'h5A, 1'b1, 1'b1, "R10 own address accepted");
    rx_char(8'h22, 1'b0, 1'b1, "R10 data accepted");
    rx_char(8'hA5, 1'b0, 1'b1, "R10 second data accepted");
    rx_char(8'h33, 1'b1, 1'b0, "R11 foreign address dropped");
    rx_char(8'h44, 1'b0, 1'b0, "R11 data dropped after foreign");
    rx_char(8'h5A, 1'b1, 1'b1, "R10 readdressed");
    filt_en = 1'b0; step();
    filt_en = 1'b1; step();
    rx_char(8'h66, 1'b0, 1'b0, "R12 match cleared by disable");
  endtask

  initial begin
    rst_n = 1'b0;
    auto_dir_en = 1'b0; man_rts = 1'b0; fc_en = 1'b0; fc_rts = 1'b0;
    tx_busy = 1'b0; tx_empty = 1'b1; bit_tick = 1'b0; turn_cnt = 8'd0;
    filt_en = 1'b0; node_addr = 8'h00; rx_valid = 1'b0;
    rx_byte = 8'h00; rx_is_addr = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_manual();
    t_auto_start();
    t_turnaround();
    t_zero_turn();
    t_retrigger();
    t_filter();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule